// File: doc/BRIEF.md
# Address-Range Transaction Tagger

This block sits on the read-address and write-address channels of an AXI link. It forwards every address beat unchanged, with one exception: a small bit slice of the user signal is overwritten with a tag number. Every transaction address is compared against a set of configurable partitions. Each partition has one address word, a two-bit match mode and a tag value. The tag of the lowest-numbered partition that matches is written into the slice. When no partition matches, the slice carries zero.

Software programs the partitions through a flat bank of 32-bit words. Each write lands in a shadow copy, and tagging keeps using the active copy. A write of bit 0 to the commit word copies the whole shadow into the active copy in a single clock edge. A half-edited set of partitions therefore never reaches live traffic. The tagging path is purely combinational, so the handshake adds no cycle.

Top module: `addr_tagger`

## Requirements
- R1: `m_aw_valid`, `m_aw_id` and `m_aw_addr` follow `s_aw_valid`, `s_aw_id` and `s_aw_addr` in the same cycle, and `s_aw_ready` follows `m_aw_ready`. The read channel behaves the same way with the `ar` signals.
- R2: On both channels, the user bits outside `[TAG_MSB:TAG_LSB]` leave the block unchanged, and the slice carries the selected tag. With the defaults, the slice is bits 4..2.
- R3: Word map. Index 0 is the commit word and always reads 0. Indices 1..NUM_PART hold the partition address words. Then come the mode words, then the tag words. A shadow word reads back what was last written to it. An index past the last word reads 0, and a write to it changes nothing. The defaults give mode word 9, tag word 10 and 11 words in all.
- R4: Partition i's mode sits at bits `2*(i%16)+1 : 2*(i%16)` of mode word `i/16`. The encodings are: 0 = disabled, 1 = below-bound range, 2 = single word, 3 = aligned power-of-two block.
- R5: In mode 1, partition i matches when `P(i-1) <= A < P(i)`. Here A is the byte address shifted right by 2, P(i) is partition i's address word, and P(-1) is 0.
- R6: In mode 2, partition i matches exactly when `A == P(i)`.
- R7: In mode 3, let k be the number of trailing one bits of P(i). The partition matches the naturally aligned region of `2^(k+3)` bytes whose word-address bits above bit k equal those of P(i).
- R8: Tag packing. Let `per = floor(32/TAG_W)`. Partition i's tag sits at bit offset `(i%per)*TAG_W` of tag word `i/per`. With the defaults, partition 7's tag occupies bits 23..21 of word 10.
- R9: When several partitions match, the lowest index wins. When none match, the tag slice is zero.
- R10: Shadow writes do not affect tagging until a write to word 0 with bit 0 set. Tagging in the cycle after that edge uses the new settings. A write to word 0 with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | REG_AW | Configuration word index for writes and reads |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Shadow readback of the word at `cfg_addr` |
| s_aw_valid | input | 1 | Upstream write-address valid |
| s_aw_ready | output | 1 | Upstream write-address ready |
| s_aw_id | input | ID_W | Upstream write-address ID |
| s_aw_addr | input | ADDR_W | Upstream write address |
| s_aw_user | input | USER_W | Upstream write-address user bits |
| m_aw_valid | output | 1 | Downstream write-address valid |
| m_aw_ready | input | 1 | Downstream write-address ready |
| m_aw_id | output | ID_W | Downstream write-address ID |
| m_aw_addr | output | ADDR_W | Downstream write address |
| m_aw_user | output | USER_W | Downstream user bits with tag slice |
| s_ar_valid | input | 1 | Upstream read-address valid |
| s_ar_ready | output | 1 | Upstream read-address ready |
| s_ar_id | input | ID_W | Upstream read-address ID |
| s_ar_addr | input | ADDR_W | Upstream read address |
| s_ar_user | input | USER_W | Upstream read-address user bits |
| m_ar_valid | output | 1 | Downstream read-address valid |
| m_ar_ready | input | 1 | Downstream read-address ready |
| m_ar_id | output | ID_W | Downstream read-address ID |
| m_ar_addr | output | ADDR_W | Downstream read address |
| m_ar_user | output | USER_W | Downstream user bits with tag slice |

## Verification
The hardest situation to reach from the ports is a transaction that hits the window between shadow edits and the commit. The shadow then already holds a different answer from the active copy.

Each random round first rewrites every partition, then sends transactions before committing. The bench model tags those transactions with the old active copy, so any leak of shadow state shows up as a wrong tag. A commit word written with bit 0 clear is also exercised.

Overlapping matches are made likely by drawing most addresses within two words of a committed partition address. Priority, range edges and aligned-block boundaries are therefore hit often rather than by chance.

// File: rtl/tagger_pkg.sv
package tagger_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_BELOW = 2'd1,
        MODE_WORD  = 2'd2,
        MODE_POW2  = 2'd3
    } part_mode_e;

    localparam int CFG_W         = 32;
    localparam int MODES_PER_REG = CFG_W / 2;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/tagger_range_match.sv
module tagger_range_match
    import tagger_pkg::*;
(
    input  logic [31:0] word_addr,
    input  logic [31:0] pat,
    input  logic [31:0] prev_pat,
    input  logic [1:0]  mode,
    output logic        hit
);
    logic [31:0] fold;

    always_comb begin
        // ones from bit 0 through the first zero of pat: the don't-care span
        fold = pat ^ (pat + 32'd1);
        case (part_mode_e'(mode))
            MODE_BELOW: hit = (word_addr >= prev_pat) && (word_addr < pat);
            MODE_WORD:  hit = (word_addr == pat);
            MODE_POW2:  hit = ((word_addr ^ pat) & ~fold) == 32'd0;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tagger_prio_pick.sv
module tagger_prio_pick #(
    parameter int NUM_PART = 8,
    parameter int TAG_W    = 3
) (
    input  logic [NUM_PART-1:0]            hits,
    input  logic [NUM_PART-1:0][TAG_W-1:0] tags,
    output logic [TAG_W-1:0]               tag_o
);
    always_comb begin
        tag_o = '0;
        // walk downward so the lowest matching index is written last
        for (int i = NUM_PART - 1; i >= 0; i--) begin
            if (hits[i]) tag_o = tags[i];
        end
    end
endmodule

// File: rtl/tagger_channel.sv
module tagger_channel #(
    parameter int NUM_PART = 8,
    parameter int ADDR_W   = 32,
    parameter int USER_W   = 8,
    parameter int TAG_LSB  = 2,
    parameter int TAG_W    = 3
) (
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [USER_W-1:0]               user_i,
    input  logic [NUM_PART-1:0][31:0]       act_addr,
    input  logic [NUM_PART-1:0][1:0]        act_mode,
    input  logic [NUM_PART-1:0][TAG_W-1:0]  act_tag,
    output logic [USER_W-1:0]               user_o
);
    localparam logic [USER_W-1:0] SLICE =
        {{(USER_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

    logic [31:0]         word_addr;
    logic [NUM_PART-1:0] hits;
    logic [TAG_W-1:0]    pick_tag;

    assign word_addr = 32'(addr_i >> 2);

    for (genvar i = 0; i < NUM_PART; i++) begin : g_part
        logic [31:0] prev_w;
        if (i == 0) begin : g_first
            assign prev_w = '0;
        end else begin : g_rest
            assign prev_w = act_addr[i-1];
        end
        tagger_range_match u_match (
            .word_addr (word_addr),
            .pat       (act_addr[i]),
            .prev_pat  (prev_w),
            .mode      (act_mode[i]),
            .hit       (hits[i])
        );
    end

    tagger_prio_pick #(.NUM_PART(NUM_PART), .TAG_W(TAG_W)) u_pick (
        .hits  (hits),
        .tags  (act_tag),
        .tag_o (pick_tag)
    );

    assign user_o = (user_i & ~SLICE) | (USER_W'(pick_tag) << TAG_LSB);
endmodule

// File: rtl/tagger_cfg_bank.sv
module tagger_cfg_bank
    import tagger_pkg::*;
#(
    parameter int NUM_PART  = 8,
    parameter int TAG_W     = 3,
    parameter int PER_REG   = 10,
    parameter int MODE_REGS = 1,
    parameter int TAG_REGS  = 1,
    parameter int REG_AW    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [REG_AW-1:0]               idx,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     rdata,
    output logic [NUM_PART-1:0][31:0]       act_addr,
    output logic [NUM_PART-1:0][1:0]        act_mode,
    output logic [NUM_PART-1:0][TAG_W-1:0]  act_tag
);
    localparam int ADDR_BASE = 1;
    localparam int MODE_BASE = ADDR_BASE + NUM_PART;
    localparam int TAG_BASE  = MODE_BASE + MODE_REGS;

    typedef struct packed {
        logic [NUM_PART-1:0][31:0]  addr;
        logic [MODE_REGS-1:0][31:0] mode;
        logic [TAG_REGS-1:0][31:0]  tag;
    } words_t;

    typedef struct packed {
        words_t shadow;
        words_t active;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (idx == REG_AW'(0)) begin
                if (wdata[0]) st_d.active = st_q.shadow;
            end
            for (int i = 0; i < NUM_PART; i++)
                if (idx == REG_AW'(ADDR_BASE + i)) st_d.shadow.addr[i] = wdata;
            for (int m = 0; m < MODE_REGS; m++)
                if (idx == REG_AW'(MODE_BASE + m)) st_d.shadow.mode[m] = wdata;
            for (int t = 0; t < TAG_REGS; t++)
                if (idx == REG_AW'(TAG_BASE + t)) st_d.shadow.tag[t] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PART; i++)
            if (idx == REG_AW'(ADDR_BASE + i)) rdata = st_q.shadow.addr[i];
        for (int m = 0; m < MODE_REGS; m++)
            if (idx == REG_AW'(MODE_BASE + m)) rdata = st_q.shadow.mode[m];
        for (int t = 0; t < TAG_REGS; t++)
            if (idx == REG_AW'(TAG_BASE + t)) rdata = st_q.shadow.tag[t];
    end

    for (genvar i = 0; i < NUM_PART; i++) begin : g_unpack
        assign act_addr[i] = st_q.active.addr[i];
        assign act_mode[i] =
            st_q.active.mode[i / MODES_PER_REG][(i % MODES_PER_REG) * 2 +: 2];
        assign act_tag[i]  =
            st_q.active.tag[i / PER_REG][(i % PER_REG) * TAG_W +: TAG_W];
    end
endmodule

// File: rtl/addr_tagger.sv
module addr_tagger
    import tagger_pkg::*;
#(
    parameter  int NUM_PART  = 8,
    parameter  int ADDR_W    = 32,
    parameter  int ID_W      = 4,
    parameter  int USER_W    = 8,
    parameter  int TAG_LSB   = 2,
    parameter  int TAG_MSB   = 4,
    localparam int TAG_W     = TAG_MSB - TAG_LSB + 1,
    localparam int PER_REG   = CFG_W / TAG_W,
    localparam int MODE_REGS = ceil_div(NUM_PART, MODES_PER_REG),
    localparam int TAG_REGS  = ceil_div(NUM_PART, PER_REG),
    localparam int NUM_REGS  = 1 + NUM_PART + MODE_REGS + TAG_REGS,
    localparam int REG_AW    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [USER_W-1:0] s_aw_user,
    output logic              m_aw_valid,
    input  logic              m_aw_ready,
    output logic [ID_W-1:0]   m_aw_id,
    output logic [ADDR_W-1:0] m_aw_addr,
    output logic [USER_W-1:0] m_aw_user,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ID_W-1:0]   s_ar_id,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [USER_W-1:0] s_ar_user,
    output logic              m_ar_valid,
    input  logic              m_ar_ready,
    output logic [ID_W-1:0]   m_ar_id,
    output logic [ADDR_W-1:0] m_ar_addr,
    output logic [USER_W-1:0] m_ar_user
);
    logic [NUM_PART-1:0][31:0]      act_addr;
    logic [NUM_PART-1:0][1:0]       act_mode;
    logic [NUM_PART-1:0][TAG_W-1:0] act_tag;

    tagger_cfg_bank #(
        .NUM_PART(NUM_PART), .TAG_W(TAG_W), .PER_REG(PER_REG),
        .MODE_REGS(MODE_REGS), .TAG_REGS(TAG_REGS), .REG_AW(REG_AW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .act_addr(act_addr), .act_mode(act_mode), .act_tag(act_tag)
    );

    tagger_channel #(
        .NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .USER_W(USER_W),
        .TAG_LSB(TAG_LSB), .TAG_W(TAG_W)
    ) u_aw_tag (
        .addr_i(s_aw_addr), .user_i(s_aw_user),
        .act_addr(act_addr), .act_mode(act_mode), .act_tag(act_tag),
        .user_o(m_aw_user)
    );

    tagger_channel #(
        .NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .USER_W(USER_W),
        .TAG_LSB(TAG_LSB), .TAG_W(TAG_W)
    ) u_ar_tag (
        .addr_i(s_ar_addr), .user_i(s_ar_user),
        .act_addr(act_addr), .act_mode(act_mode), .act_tag(act_tag),
        .user_o(m_ar_user)
    );

    assign m_aw_valid = s_aw_valid;
    assign m_aw_id    = s_aw_id;
    assign m_aw_addr  = s_aw_addr;
    assign s_aw_ready = m_aw_ready;
    assign m_ar_valid = s_ar_valid;
    assign m_ar_id    = s_ar_id;
    assign m_ar_addr  = s_ar_addr;
    assign s_ar_ready = m_ar_ready;
endmodule

// File: rtl/tagger_checker.sv
module tagger_checker #(
    parameter int NUM_PART = 8,
    parameter int ADDR_W   = 32,
    parameter int USER_W   = 8,
    parameter int TAG_LSB  = 2,
    parameter int TAG_MSB  = 4,
    parameter int TAG_W    = 3,
    parameter int REG_AW   = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [REG_AW-1:0]              cfg_addr,
    input logic [31:0]                    cfg_rdata,
    input logic [USER_W-1:0]              s_aw_user,
    input logic [USER_W-1:0]              m_aw_user,
    input logic [USER_W-1:0]              m_ar_user,
    input logic [ADDR_W-1:0]              s_ar_addr,
    input logic [NUM_PART-1:0][31:0]      act_addr,
    input logic [NUM_PART-1:0][1:0]       act_mode,
    input logic [NUM_PART-1:0][TAG_W-1:0] act_tag
);
    localparam logic [USER_W-1:0] KEEP =
        ~({{(USER_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB);

    logic [31:0] ar_word;
    assign ar_word = 32'(s_ar_addr >> 2);

    // R10: the active copy moves only on a configuration write
    assert_hold_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(act_addr) && $stable(act_mode) && $stable(act_tag)));

    // R3: the commit word never reads back a set bit
    assert_commit_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == REG_AW'(0)) |-> (cfg_rdata == 32'd0));

    // R2: bits outside the tag slice are carried through
    assert_keep_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_aw_user ^ s_aw_user) & KEEP) == '0);

    // R9: with every partition disabled the slice is zero
    assert_no_match_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == '0) |-> (m_aw_user[TAG_MSB:TAG_LSB] == '0
                              && m_ar_user[TAG_MSB:TAG_LSB] == '0));

    // R6: a single-word hit on partition 0 always wins
    assert_word_hit_p0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode[0] == 2'd2 && ar_word == act_addr[0])
            |-> (m_ar_user[TAG_MSB:TAG_LSB] == act_tag[0]));
endmodule

bind addr_tagger tagger_checker #(
    .NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .USER_W(USER_W),
    .TAG_LSB(TAG_LSB), .TAG_MSB(TAG_MSB), .TAG_W(TAG_W), .REG_AW(REG_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_rdata(cfg_rdata), .s_aw_user(s_aw_user), .m_aw_user(m_aw_user),
    .m_ar_user(m_ar_user), .s_ar_addr(s_ar_addr), .act_addr(act_addr),
    .act_mode(act_mode), .act_tag(act_tag)
);

// File: tb/sim_addr_tagger.sv
`timescale 1ns/1ps
module sim_addr_tagger;
    localparam int NP = 8;

    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0, cfg_rdata;
    logic        s_aw_valid = 0, s_aw_ready, m_aw_valid, m_aw_ready = 1;
    logic [3:0]  s_aw_id = 0, m_aw_id;
    logic [31:0] s_aw_addr = 0, m_aw_addr;
    logic [7:0]  s_aw_user = 0, m_aw_user;
    logic        s_ar_valid = 0, s_ar_ready, m_ar_valid, m_ar_ready = 1;
    logic [3:0]  s_ar_id = 0, m_ar_id;
    logic [31:0] s_ar_addr = 0, m_ar_addr;
    logic [7:0]  s_ar_user = 0, m_ar_user;

    always #10 clk = ~clk;

    addr_tagger u0 (.*);

    typedef struct {
        logic [3:0]  id;
        logic [31:0] addr;
        logic [7:0]  user;
        string       req;
    } item_t;
    item_t q_aw[$], q_ar[$];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] sh_addr [NP], ac_addr [NP];
    logic [1:0]  sh_mode [NP], ac_mode [NP];
    logic [2:0]  sh_tag  [NP], ac_tag  [NP];

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_tag(input logic [31:0] byte_addr);
        logic [31:0] a, lo;
        int k;
        bit m;
        a = {2'b00, byte_addr[31:2]};
        for (int i = 0; i < NP; i++) begin
            m = 0;
            lo = (i == 0) ? 32'd0 : ac_addr[i-1];
            case (ac_mode[i])
                2'd1: m = (a >= lo) && (a < ac_addr[i]);
                2'd2: m = (a == ac_addr[i]);
                2'd3: begin
                    k = 0;
                    while (k < 32 && ac_addr[i][k]) k++;
                    m = (k + 1 >= 32) ? 1'b1 : ((a >> (k + 1)) == (ac_addr[i] >> (k + 1)));
                end
                default: m = 0;
            endcase
            if (m) return ac_tag[i];
        end
        return 3'd0;
    endfunction

    task automatic cfg_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd_check(input logic [3:0] idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = idx;
        #5;
        check(cfg_rdata == exp, $sformatf("%s readback word %0d", req, idx), cfg_rdata, exp);
    endtask

    task automatic set_part(input int i, input logic [31:0] a, input logic [1:0] md,
                            input logic [2:0] tg);
        logic [31:0] mw, tw;
        sh_addr[i] = a; sh_mode[i] = md; sh_tag[i] = tg;
        mw = 0; tw = 0;
        for (int j = 0; j < NP; j++) begin
            mw |= 32'(sh_mode[j]) << (2 * j);
            tw |= 32'(sh_tag[j]) << (3 * j);
        end
        cfg_write(4'(1 + i), a);
        cfg_write(4'd9, mw);
        cfg_write(4'd10, tw);
    endtask

    task automatic commit();
        cfg_write(4'd0, 32'h1);
        for (int j = 0; j < NP; j++) begin
            ac_addr[j] = sh_addr[j]; ac_mode[j] = sh_mode[j]; ac_tag[j] = sh_tag[j];
        end
    endtask

    task automatic send(input bit ar, input logic [31:0] a, input logic [3:0] id,
                        input logic [7:0] u, input string req);
        item_t it;
        it.id = id; it.addr = a; it.req = req;
        it.user = (u & ~8'h1C) | {3'b000, ref_tag(a), 2'b00};
        @(negedge clk);
        if (ar) begin
            s_ar_valid = 1; s_ar_id = id; s_ar_addr = a; s_ar_user = u;
            q_ar.push_back(it);
        end else begin
            s_aw_valid = 1; s_aw_id = id; s_aw_addr = a; s_aw_user = u;
            q_aw.push_back(it);
        end
        @(negedge clk);
        s_ar_valid = 0; s_aw_valid = 0;
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        #5;
        if (m_aw_valid) begin
            if (q_aw.size() == 0) check(0, "R1 unexpected aw beat", 1, 0);
            else begin
                item_t e;
                e = q_aw.pop_front();
                check(m_aw_user == e.user, {e.req, " aw user"}, 32'(m_aw_user), 32'(e.user));
                check(m_aw_addr == e.addr && m_aw_id == e.id, "R1 aw addr/id",
                      m_aw_addr, e.addr);
            end
        end
        if (m_ar_valid) begin
            if (q_ar.size() == 0) check(0, "R1 unexpected ar beat", 1, 0);
            else begin
                item_t e;
                e = q_ar.pop_front();
                check(m_ar_user == e.user, {e.req, " ar user"}, 32'(m_ar_user), 32'(e.user));
                check(m_ar_addr == e.addr && m_ar_id == e.id, "R1 ar addr/id",
                      m_ar_addr, e.addr);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < NP; j++) begin
            sh_addr[j] = 0; sh_mode[j] = 0; sh_tag[j] = 0;
            ac_addr[j] = 0; ac_mode[j] = 0; ac_tag[j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        for (int w = 0; w < 11; w++) rd_check(4'(w), 32'd0, "R3");
        send(0, 32'h0000_0100, 4'h1, 8'hFF, "R9 reset no match");
        send(1, 32'h0000_0100, 4'h2, 8'hFF, "R9 reset no match");

        // shadow edits are not live (R10)
        set_part(0, 32'h40, 2'd2, 3'd5);
        rd_check(4'd1, 32'h40, "R3");
        rd_check(4'd9, 32'h2, "R4");
        rd_check(4'd10, 32'h5, "R8");
        send(0, 32'h0000_0100, 4'h3, 8'h00, "R10 before commit");
        cfg_write(4'd0, 32'hFFFF_FFFE);
        send(1, 32'h0000_0100, 4'h4, 8'h00, "R10 commit bit clear");
        rd_check(4'd0, 32'd0, "R10");
        commit();
        send(1, 32'h0000_0100, 4'h5, 8'h00, "R6 R10 word hit");
        send(0, 32'h0000_0104, 4'h6, 8'hA5, "R6 next word miss");

        // below-bound range and priority
        set_part(1, 32'h80, 2'd1, 3'd3);
        set_part(7, 32'h407, 2'd3, 3'd6);
        rd_check(4'd9, 32'h0000_C006, "R4");
        rd_check(4'd10, 32'h00C0_001D, "R8");
        commit();
        send(0, 32'h0000_0100, 4'h7, 8'h00, "R9 lowest index wins");
        send(1, 32'h0000_0104, 4'h8, 8'h00, "R5 range inside");
        send(0, 32'h0000_01FC, 4'h9, 8'h00, "R5 range top");
        send(1, 32'h0000_0200, 4'hA, 8'h00, "R5 range end");
        send(0, 32'h0000_00FC, 4'hB, 8'h00, "R5 below lower bound");
        // aligned power-of-two block: 64 bytes at 0x1000, tag in bits 23..21
        send(1, 32'h0000_1000, 4'hC, 8'h03, "R7 R8 block base");
        send(0, 32'h0000_103F, 4'hD, 8'hE0, "R7 R8 block top");
        send(1, 32'h0000_1040, 4'hE, 8'hFF, "R7 past block");
        send(0, 32'h0000_0FFC, 4'hF, 8'h1C, "R7 before block");

        // unmapped word
        cfg_write(4'd15, 32'hDEAD_BEEF);
        rd_check(4'd15, 32'd0, "R3");
        send(1, 32'h0000_1000, 4'h1, 8'h00, "R3 unmapped write ignored");

        // ready passthrough
        @(negedge clk);
        m_aw_ready = 0; m_ar_ready = 1;
        #5;
        check(s_aw_ready == 0 && s_ar_ready == 1, "R1 ready follows", 32'({s_aw_ready, s_ar_ready}), 32'b01);
        @(negedge clk);
        m_aw_ready = 1; m_ar_ready = 0;
        #5;
        check(s_aw_ready == 1 && s_ar_ready == 0, "R1 ready follows", 32'({s_aw_ready, s_ar_ready}), 32'b10);
        m_ar_ready = 1;

        // random rounds with reconfiguration between bursts
        for (int r = 0; r < 12; r++) begin
            for (int p = 0; p < NP; p++) begin
                logic [1:0] md;
                logic [31:0] a;
                int k;
                md = 2'($urandom % 4);
                if (md == 2'd3) begin
                    k = $urandom % 6;
                    a = ($urandom & 32'h3FF & ~((32'd1 << (k + 1)) - 1)) | ((32'd1 << k) - 1);
                end else begin
                    a = $urandom & 32'h3FF;
                end
                set_part(p, a, md, 3'($urandom % 8));
            end
            for (int t = 0; t < 4; t++)
                send(t[0], {ac_addr[$urandom % NP][29:0], 2'b00}, 4'(t), 8'($urandom),
                     "R10 random pre-commit");
            commit();
            for (int t = 0; t < 40; t++) begin
                logic [31:0] w, a;
                w = ac_addr[$urandom % NP] + 32'($urandom % 5) - 32'd2;
                a = ($urandom % 4 == 0) ? ($urandom & 32'h0000_1FFF)
                                        : {w[29:0], 2'($urandom)};
                send(t[0], a, 4'($urandom), 8'($urandom), "R2 R5 R6 R7 R9 random");
            end
        end

        repeat (3) @(negedge clk);
        check(q_aw.size() == 0 && q_ar.size() == 0, "R1 all beats forwarded",
              32'(q_aw.size() + q_ar.size()), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule